// File: doc/BRIEF.md
# H-Bridge Direction, Modulation and Fault-Latch Controller

This block is the digital control core of a full H-bridge made of two half-bridge legs (A and B). Each leg has one high-side and one low-side switch. The block receives a direction bit for each leg and a speed-modulation (PWM) level. It also receives the sensed level of each leg's shared open-drain enable/diagnostic line, and ready-made protection flags: high-side overtemperature and low-side saturation for each leg, plus supply undervoltage and overvoltage. It produces the four gate enables, a pull-down request for each diagnostic line, and an enable and leg select for the current-sense path.

Every asynchronous input first passes through a two-flop synchronizer. Each direction change is then held back by a settling filter of `MODE_DLY` clocks before it reaches the legs. Each leg applies its own break-before-make gap of `DEAD_T` clocks before it hands conduction from one side to the other. A protection event on a leg latches that leg off and pulls its diagnostic line low. Only a fresh low-to-high edge on that leg's own direction input releases the latch. The block has no streaming data path, so every pin is a plain level-sensitive control or status signal.

Top module: `hbridge_ctrl`

## Requirements
- R1: The committed direction pair {dir_a, dir_b} selects the leg outputs. The pair 11 turns both high sides on, the pair 00 turns both low sides on, 10 turns on hs_a and ls_b, and 01 turns on ls_a and hs_b.
- R2: While pwm is 0, ls_a and ls_b are both off. When pwm returns to 1, the selected low side turns on again. The high sides ignore pwm.
- R3: A low level on a leg's diagnostic line that the block did not cause disables that leg: both of its gates are off. The other leg is unaffected.
- R4: A high overtemperature or saturation flag on a leg latches that leg off and drives its pull-down output high. The latch holds after the flag clears. A rise of the pull-down output is always preceded, three clocks earlier, by that leg's flag being high.
- R5: A latched leg is released only by a low-to-high edge on its own direction input that occurs once the flag is clear. A falling edge alone does not release it. While one leg is latched, the other leg keeps following its own direction input.
- R6: While uv or ov is high, all four gates are off (three clocks after the flag is sampled). Normal control resumes once both flags are clear.
- R7: sense_en is 1 exactly when one high side is on and the other is off. sense_sel is then 1 for leg B and 0 for leg A. In both brake modes sense_en is 0. When leg A is latched and dir_b is 1, sense_en is 1 with sense_sel 1.
- R8: A new direction pair reaches the gates only after it has been stable for MODE_DLY clocks past the synchronizer. Five clocks after a change, the outputs still show the old mode.
- R9: The high and low side of one leg are never on together. When a leg hands over between sides, both of its gates are off for at least DEAD_T+1 sampled cycles, and the gate that has just turned off never lets the other side on in the next cycle.
- R10: While the block is pulling a diagnostic line low, the low level it reads on that line is not taken as an external disable. A latched leg can therefore be released through its direction input alone.
- R11: During reset, all gates, both pull-downs and sense_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dir_a | input | 1 | Direction request for leg A (async) |
| dir_b | input | 1 | Direction request for leg B (async) |
| pwm | input | 1 | Speed modulation level, gates the low sides (async) |
| line_a | input | 1 | Sensed level of leg A enable/diagnostic line |
| line_b | input | 1 | Sensed level of leg B enable/diagnostic line |
| ot_a | input | 1 | Leg A high-side overtemperature flag |
| ot_b | input | 1 | Leg B high-side overtemperature flag |
| sat_a | input | 1 | Leg A low-side saturation flag |
| sat_b | input | 1 | Leg B low-side saturation flag |
| uv | input | 1 | Supply undervoltage flag |
| ov | input | 1 | Supply overvoltage flag |
| hs_a | output | 1 | Leg A high-side gate enable |
| ls_a | output | 1 | Leg A low-side gate enable |
| hs_b | output | 1 | Leg B high-side gate enable |
| ls_b | output | 1 | Leg B low-side gate enable |
| pd_a | output | 1 | Pull-down request for line A (fault) |
| pd_b | output | 1 | Pull-down request for line B (fault) |
| sense_en | output | 1 | Current sense path enable |
| sense_sel | output | 1 | Sensed leg: 0 = A, 1 = B |

## Verification
A corrupted fault latch shows up as a pull-down that stays high, or as one that clears without a direction edge. In either case the wrong gate pattern is visible within three clocks of the flag or edge. A wrong committed mode or a miscounting settling filter shows as gates that change too early (five clocks after a change) or never change. A broken idle counter shows as a gap between sides shorter than the dead time, or as both gates of a leg on together, which the overlap watch catches in the very cycle it happens.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // Committed direction pair {leg A, leg B}
  typedef enum logic [1:0] {
    MODE_BRAKE_LO = 2'b00,
    MODE_REV      = 2'b01,
    MODE_FWD      = 2'b10,
    MODE_BRAKE_HI = 2'b11
  } hb_mode_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [hb_pkg::SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < hb_pkg::SYNC_STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < hb_pkg::SYNC_STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[hb_pkg::SYNC_STAGES-1];
endmodule

// File: rtl/hb_mode_filter.sv
module hb_mode_filter #(
  parameter int MODE_DLY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hb_pkg::hb_mode_e req,
  output hb_pkg::hb_mode_e mode
);
  localparam int CW = (MODE_DLY < 2) ? 1 : $clog2(MODE_DLY);

  hb_pkg::hb_mode_e pend_q, mode_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= hb_pkg::MODE_BRAKE_LO;
      mode_q <= hb_pkg::MODE_BRAKE_LO;
      cnt_q  <= '0;
    end else if (req != pend_q) begin
      pend_q <= req;
      cnt_q  <= '0;
    end else if (pend_q != mode_q) begin
      if (cnt_q == CW'(MODE_DLY - 1)) begin
        mode_q <= pend_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
  parameter int DEAD_T = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_high,
  input  logic pwm,
  input  logic line,
  input  logic dir_raw,
  input  logic prot,
  input  logic supply_ok,
  output logic hs,
  output logic ls,
  output logic pd
);
  localparam int IW = (DEAD_T < 1) ? 1 : $clog2(DEAD_T + 1);

  logic          dir_prev_q, fault_q, fault_d;
  logic          hs_q, ls_q, last_hs_q;
  logic [IW-1:0] idle_q;
  logic          idle_ok, run, want_hs, want_ls, hs_d, ls_d;

  // release only on a fresh rising edge of this leg's own direction input
  assign fault_d = prot | (fault_q & ~(dir_raw & ~dir_prev_q));
  // own pull-down masks the line, so the leg cannot disable itself
  assign run     = ~fault_d & supply_ok & (line | fault_q);
  assign want_hs = run & cmd_high;
  assign want_ls = run & ~cmd_high & pwm;
  assign idle_ok = (32'(idle_q) >= DEAD_T);
  assign hs_d    = want_hs & ~ls_q & (hs_q | last_hs_q | idle_ok);
  assign ls_d    = want_ls & ~hs_q & (ls_q | ~last_hs_q | idle_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_prev_q <= 1'b0;
      fault_q    <= 1'b0;
      hs_q       <= 1'b0;
      ls_q       <= 1'b0;
      last_hs_q  <= 1'b0;
      idle_q     <= IW'(DEAD_T);
    end else begin
      dir_prev_q <= dir_raw;
      fault_q    <= fault_d;
      hs_q       <= hs_d;
      ls_q       <= ls_d;
      if (hs_q) last_hs_q <= 1'b1;
      else if (ls_q) last_hs_q <= 1'b0;
      if (hs_q | ls_q) idle_q <= '0;
      else if (!idle_ok) idle_q <= idle_q + 1'b1;
    end
  end

  assign hs = hs_q;
  assign ls = ls_q;
  assign pd = fault_q;
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl #(
  parameter int MODE_DLY = 8,
  parameter int DEAD_T   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_a,
  input  logic dir_b,
  input  logic pwm,
  input  logic line_a,
  input  logic line_b,
  input  logic ot_a,
  input  logic ot_b,
  input  logic sat_a,
  input  logic sat_b,
  input  logic uv,
  input  logic ov,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b,
  output logic pd_a,
  output logic pd_b,
  output logic sense_en,
  output logic sense_sel
);
  localparam int NLEG = 2;
  localparam int NIN  = 3 * NLEG + 3;

  logic [NIN-1:0]   raw_in, syn;
  logic [NLEG-1:0]  s_dir, s_line, s_prot, hs_v, ls_v, pd_v;
  logic             s_pwm, s_supply_ok;
  hb_pkg::hb_mode_e mode;

  assign raw_in = {uv, ov, pwm, ot_b | sat_b, ot_a | sat_a,
                   line_b, line_a, dir_b, dir_a};

  hb_sync #(.W(NIN)) u_sync (.clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn));

  assign s_dir       = syn[1:0];
  assign s_line      = syn[3:2];
  assign s_prot      = syn[5:4];
  assign s_pwm       = syn[6];
  assign s_supply_ok = ~(syn[7] | syn[8]);

  hb_mode_filter #(.MODE_DLY(MODE_DLY)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .req(hb_pkg::hb_mode_e'({s_dir[0], s_dir[1]})),
    .mode(mode)
  );

  // index 0 = leg A (mode bit 1), index 1 = leg B (mode bit 0)
  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb_leg #(.DEAD_T(DEAD_T)) u_leg (
      .clk(clk), .rst_n(rst_n),
      .cmd_high(mode[NLEG-1-g]),
      .pwm(s_pwm),
      .line(s_line[g]),
      .dir_raw(s_dir[g]),
      .prot(s_prot[g]),
      .supply_ok(s_supply_ok),
      .hs(hs_v[g]), .ls(ls_v[g]), .pd(pd_v[g])
    );
  end

  assign hs_a      = hs_v[0];
  assign ls_a      = ls_v[0];
  assign hs_b      = hs_v[1];
  assign ls_b      = ls_v[1];
  assign pd_a      = pd_v[0];
  assign pd_b      = pd_v[1];
  assign sense_en  = hs_v[0] ^ hs_v[1];
  assign sense_sel = hs_v[1] & ~hs_v[0];
endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ot_a,
  input logic sat_a,
  input logic ot_b,
  input logic sat_b,
  input logic uv,
  input logic ov,
  input logic hs_a,
  input logic ls_a,
  input logic hs_b,
  input logic ls_b,
  input logic pd_a,
  input logic pd_b
);
  // R9
  shoot_through_a_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hs_a && ls_a));
  // R9
  shoot_through_b_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hs_b && ls_b));
  // R9
  handover_gap_a_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(hs_a) |=> !ls_a);
  // R9
  handover_gap_b_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(hs_b) |=> !ls_b);
  // R4
  latch_cause_a_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(pd_a) |-> $past(ot_a | sat_a, 3));
  // R4
  latch_cause_b_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(pd_b) |-> $past(ot_b | sat_b, 3));
  // R4
  latched_off_a_chk: assert property (@(posedge clk) disable iff (!rst_n) pd_a |-> !hs_a && !ls_a);
  // R6
  supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uv | ov, 3) |-> !hs_a && !ls_a && !hs_b && !ls_b);
endmodule

bind hbridge_ctrl hbridge_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ot_a(ot_a), .sat_a(sat_a), .ot_b(ot_b), .sat_b(sat_b),
  .uv(uv), .ov(ov), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b),
  .pd_a(pd_a), .pd_b(pd_b)
);

// File: tb/tb_hbridge_ctrl.sv
module tb_hbridge_ctrl;
  localparam int MODE_DLY = 8;
  localparam int DEAD_T   = 3;
  localparam int SETTLE   = 40;
  localparam int NVEC     = 11;

  // {dir_a,dir_b,pwm,ext_a,ext_b,uv,ov} -> {hs_a,ls_a,hs_b,ls_b,sense_en,sense_sel}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b1111100_101000, // R1 brake high, R7 no sense
    13'b1011100_100110, // R1 forward, R7 sense A
    13'b0111100_011011, // R1 reverse, R7 sense B
    13'b0011100_010100, // R1 brake low
    13'b1001100_100010, // R2 pwm low, high side kept
    13'b0001100_000000, // R2 pwm low, both low sides off
    13'b1011000_100010, // R3 leg B disabled
    13'b0110100_001011, // R3 leg A disabled
    13'b1011110_000000, // R6 undervoltage
    13'b0111101_000000, // R6 overvoltage
    13'b0011100_010100  // R6 resume
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_a = 0, dir_b = 0, pwm = 0, ext_a = 1, ext_b = 1;
  logic ot_a = 0, ot_b = 0, sat_a = 0, sat_b = 0, uv = 0, ov = 0;
  logic hs_a, ls_a, hs_b, ls_b, pd_a, pd_b, sense_en, sense_sel;
  logic line_a, line_b;
  int   checks = 0, fails = 0, overlaps = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  // open-drain line: pulled low by outside or by the block
  assign line_a = ext_a & ~pd_a;
  assign line_b = ext_b & ~pd_b;

  hbridge_ctrl #(.MODE_DLY(MODE_DLY), .DEAD_T(DEAD_T)) dut (
    .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b), .pwm(pwm),
    .line_a(line_a), .line_b(line_b), .ot_a(ot_a), .ot_b(ot_b),
    .sat_a(sat_a), .sat_b(sat_b), .uv(uv), .ov(ov),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b),
    .pd_a(pd_a), .pd_b(pd_b), .sense_en(sense_en), .sense_sel(sense_sel)
  );

  always @(negedge clk) if (rst_n && ((hs_a && ls_a) || (hs_b && ls_b))) overlaps++;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] gates();
    return {2'b00, hs_a, ls_a, hs_b, ls_b, sense_en, sense_sel};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    int gap;
    // R11 reset state
    settle(3);
    chk("R11", {gates(), 2'b00} >> 2 | {6'd0, pd_a, pd_b}, 8'd0);
    rst_n = 1'b1;
    settle(5);

    for (int i = 0; i < NVEC; i++) begin
      {dir_a, dir_b, pwm, ext_a, ext_b, uv, ov} = VEC[i][12:6];
      settle(SETTLE);
      chk($sformatf("R1/R2/R3/R6/R7 vector %0d", i), gates(), {2'b00, VEC[i][5:0]});
    end

    // R4 latch on leg A while running forward
    dir_a = 1; dir_b = 0; pwm = 1; settle(SETTLE);
    ot_a = 1; settle(5); ot_a = 0; settle(SETTLE);
    chk("R4 leg A latched", {6'd0, hs_a | ls_a, pd_a}, 8'b01);
    chk("R5 leg B unaffected", {7'd0, ls_b}, 8'd1);
    // R5 falling edge alone does not release
    dir_a = 0; settle(SETTLE);
    chk("R5 no release on fall", {7'd0, pd_a}, 8'd1);
    // R5 / R10 rising edge releases despite the line being pulled low by the block
    dir_a = 1; settle(SETTLE);
    chk("R5/R10 released", {6'd0, pd_a, hs_a}, 8'b01);

    // R7 leg A latched in reverse, sense still reports leg B
    dir_a = 0; dir_b = 1; settle(SETTLE);
    sat_a = 1; settle(5); sat_a = 0; settle(SETTLE);
    chk("R7 sense with leg A latched", {4'd0, pd_a, hs_b, sense_en, sense_sel}, 8'b1111);
    chk("R4 leg A low side off", {7'd0, ls_a}, 8'd0);
    // R5 short rising pulse releases without changing the committed mode
    dir_a = 1; settle(3); dir_a = 0; settle(SETTLE);
    chk("R5 pulse release", {6'd0, pd_a, ls_a}, 8'b01);

    // R8 mode change held back
    dir_a = 1; dir_b = 0; settle(5);
    chk("R8 old mode kept", gates(), 8'b00011011);
    settle(SETTLE);
    chk("R8 new mode applied", gates(), 8'b00100110);

    // R9 handover gap on leg A: high side to low side
    dir_a = 0; dir_b = 1;
    while (hs_a) @(negedge clk);
    gap = 0;
    for (int k = 0; k < 60 && !ls_a; k++) begin
      gap++;
      @(negedge clk);
    end
    chk("R9 gap length", (gap >= DEAD_T + 1) ? 8'd1 : 8'd0, 8'd1);
    settle(SETTLE);
    chk("R9 no overlap seen", overlaps[7:0], 8'd0);

    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule